// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge lets a 64-bit register port reach a 32-bit internal request/response bus through four 8-byte registers. The register index comes from address bits [4:3]. A write to the command register starts exactly one internal bus transaction. That transaction is either a read or a write, with a 32-bit target address and a byte count both taken from the command word. Outbound write data comes from a separate data register.

The command is held on the internal bus until the responder acknowledges it. At that point a completion word goes into the status register. For reads, the completion word carries the returned bytes packed into its middle, or an all-ones pattern when the read failed. Reading the status register returns the completion word and then clears it, so software polls status for the done flag and picks the read data out of the same word.

Top module: `ind_reg_bridge`

## Requirements
- R1: The index is regAddr[4:3]: 0 = command, 1 = reset, 2 = status, 3 = data. Register reads return data combinationally in the cycle regValid is high. Reads of the command and reset registers return zero.
- R2: A write to the data register stores regWdata[63:32]. A read of it returns the stored value in bits [63:32] with zeros in bits [31:0].
- R3: A command write while idle raises busReq from the next cycle. It presents busAddr = regWdata[31:0] and busWrite = NOT regWdata[48] (bit 48 set means read). It presents busSize from regWdata[59:56].
- R4: A size field of 0, or of more than 4, is presented as 4 on busSize.
- R5: busReq and the command fields stay constant until busAck is sampled high, and busReq is low in the cycle after that. A command write while busReq is high is ignored and is never started later.
- R6: A read acknowledged with busOk = 1 sets status to bit 11 (done) plus the returned word shifted left by 26. busRdata[31:24] is the first byte and the most significant one. Bytes at or beyond the size are forced to zero.
- R7: A read acknowledged with busOk = 0 sets status to bit 11 plus 32'hFFFFFFFF shifted left by 26.
- R8: A write transaction drives busWdata with the data register value held when the command was accepted. When it completes, status is exactly bit 11, whatever busOk says.
- R9: A status read returns the current status, and the status is zero from the next cycle. If a completion is captured in the same cycle, the new completion word wins over the clear.
- R10: Writes to the reset and status registers change neither the status nor the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regValid | input | 1 | Register access strobe, one cycle per access |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | REG_ADDR_W | Byte address of the access; bits [4:3] pick the register |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Read data, valid while regValid is high |
| busReq | output | 1 | Internal bus request, held until acknowledged |
| busWrite | output | 1 | 1 = write transaction, 0 = read |
| busAddr | output | 32 | Target address |
| busSize | output | 3 | Byte count, 1 to 4 |
| busWdata | output | 32 | Write data, first byte in bits [31:24] |
| busAck | input | 1 | Response strobe from the bus |
| busOk | input | 1 | Response success flag |
| busRdata | input | 32 | Read data, first byte in bits [31:24] |

## Verification
A wrong busy state shows up at the ports in one of two ways: busReq stays high after the acknowledge, or busAddr changes mid-transaction when a second command is written. Either is visible one cycle after the event. A bad status register shows on the very next status read, whether as a stale word after a clear, a missing done bit, or data in the wrong lane or with unmasked tail bytes. Randomized commands with random latency, size and success cover the packing against an independent model. Directed cases pin the clamp, the busy drop and the clear-versus-capture collision.

// File: rtl/ind_reg_bridge_pkg.sv
package ind_reg_bridge_pkg;
  localparam int REG_W         = 64;
  localparam int BUS_AW        = 32;
  localparam int BUS_DW        = 32;
  localparam int BUS_BYTES     = BUS_DW / 8;
  localparam int SIZE_W        = $clog2(BUS_BYTES) + 1;
  // command word fields (LSB numbering)
  localparam int CMD_RD_BIT    = 48;
  localparam int CMD_SZ_LO     = 56;
  localparam int CMD_SZ_W      = 4;
  // status word fields
  localparam int STAT_DONE_BIT = 11;
  localparam int STAT_DATA_LO  = 26;
  // data register position inside the 64-bit word
  localparam int DATA_LO       = REG_W - BUS_DW;

  typedef enum logic [1:0] {
    IDX_CMD   = 2'd0,
    IDX_RESET = 2'd1,
    IDX_STAT  = 2'd2,
    IDX_DATA  = 2'd3
  } regIdx_t;

  typedef struct packed {
    logic cmdAccept;
    logic dataWrite;
    logic statClear;
    logic respCapture;
  } strobes_t;
endpackage

// File: rtl/ind_reg_bridge_ctrl.sv
module ind_reg_bridge_ctrl
  import ind_reg_bridge_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     regValid,
  input  logic     regWrite,
  input  regIdx_t  regIdx,
  input  logic     busAck,
  output strobes_t stb,
  output logic     busReq
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_t;
  state_t stateQ, stateD;

  always_comb begin
    stb.cmdAccept   = regValid && regWrite && (regIdx == IDX_CMD) && (stateQ == ST_IDLE);
    stb.dataWrite   = regValid && regWrite && (regIdx == IDX_DATA);
    stb.statClear   = regValid && !regWrite && (regIdx == IDX_STAT);
    stb.respCapture = (stateQ == ST_BUSY) && busAck;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (stb.cmdAccept)   stateD = ST_BUSY;
      ST_BUSY: if (stb.respCapture) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busReq = (stateQ == ST_BUSY);
endmodule

// File: rtl/ind_reg_bridge_dp.sv
module ind_reg_bridge_dp
  import ind_reg_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  regIdx_t           regIdx,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              busWrite,
  output logic [BUS_AW-1:0] busAddr,
  output logic [SIZE_W-1:0] busSize,
  output logic [BUS_DW-1:0] busWdata,
  input  logic              busOk,
  input  logic [BUS_DW-1:0] busRdata,
  output logic [REG_W-1:0]  statVal
);
  logic [BUS_DW-1:0]   dataQ;
  logic [REG_W-1:0]    statQ;
  logic [CMD_SZ_W-1:0] rawSize;
  logic [SIZE_W-1:0]   clampSize;
  logic [BUS_DW-1:0]   keptData;
  logic [BUS_DW-1:0]   readField;
  logic [REG_W-1:0]    doneWord;

  // size clamp: zero or oversize requests become a full word
  assign rawSize   = regWdata[CMD_SZ_LO +: CMD_SZ_W];
  assign clampSize = (rawSize == '0 || rawSize > CMD_SZ_W'(BUS_BYTES))
                     ? SIZE_W'(BUS_BYTES) : rawSize[SIZE_W-1:0];

  // command hold registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busWrite <= 1'b0;
      busAddr  <= '0;
      busSize  <= SIZE_W'(BUS_BYTES);
      busWdata <= '0;
    end else if (stb.cmdAccept) begin
      busWrite <= !regWdata[CMD_RD_BIT];
      busAddr  <= regWdata[BUS_AW-1:0];
      busSize  <= clampSize;
      busWdata <= dataQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataQ <= '0;
    else if (stb.dataWrite) dataQ <= regWdata[DATA_LO +: BUS_DW];
  end

  // byte lanes, first byte most significant; lanes past the size read zero
  for (genvar b = 0; b < BUS_BYTES; b++) begin : g_lane
    localparam int HI = BUS_DW - 1 - 8 * b;
    assign keptData[HI -: 8] = (SIZE_W'(b) < busSize) ? busRdata[HI -: 8] : 8'h00;
  end

  assign readField = busOk ? keptData : '1;

  always_comb begin
    doneWord = '0;
    doneWord[STAT_DONE_BIT] = 1'b1;
    if (!busWrite) doneWord[STAT_DATA_LO +: BUS_DW] = readField;
  end

  // completion beats the read-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                statQ <= '0;
    else if (stb.respCapture) statQ <= doneWord;
    else if (stb.statClear)   statQ <= '0;
  end

  always_comb begin
    unique case (regIdx)
      IDX_STAT: regRdata = statQ;
      IDX_DATA: regRdata = {dataQ, {DATA_LO{1'b0}}};
      default:  regRdata = '0;
    endcase
  end

  assign statVal = statQ;
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ind_reg_bridge_pkg::*;
#(
  parameter int REG_ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regValid,
  input  logic                  regWrite,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [63:0]           regWdata,
  output logic [63:0]           regRdata,
  output logic                  busReq,
  output logic                  busWrite,
  output logic [31:0]           busAddr,
  output logic [2:0]            busSize,
  output logic [31:0]           busWdata,
  input  logic                  busAck,
  input  logic                  busOk,
  input  logic [31:0]           busRdata
);
  localparam int IDX_LO = 3;

  regIdx_t          regIdx;
  strobes_t         stb;
  logic [REG_W-1:0] statVal;

  assign regIdx = regIdx_t'(regAddr[IDX_LO +: 2]);

  ind_reg_bridge_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regValid (regValid),
    .regWrite (regWrite),
    .regIdx   (regIdx),
    .busAck   (busAck),
    .stb      (stb),
    .busReq   (busReq)
  );

  ind_reg_bridge_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regIdx   (regIdx),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .busWdata (busWdata),
    .busOk    (busOk),
    .busRdata (busRdata),
    .statVal  (statVal)
  );
endmodule

// File: rtl/ind_reg_bridge_chk.sv
module ind_reg_bridge_chk #(
  parameter int REG_ADDR_W = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regValid,
  input logic                  regWrite,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic                  busReq,
  input logic                  busWrite,
  input logic [31:0]           busAddr,
  input logic [2:0]            busSize,
  input logic                  busAck,
  input logic                  busOk,
  input logic [63:0]           statVal
);
  logic capture;
  logic [1:0] idx;
  assign capture = busReq && busAck;
  assign idx     = regAddr[4:3];

  p_size_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busSize >= 3'd1 && busSize <= 3'd4));

  p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busWrite) && $stable(busSize)));

  p_drop_after_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> !busReq);

  p_done_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> statVal[11]);

  p_fail_pattern_r7: assert property (@(posedge clk) disable iff (!rstN)
    (capture && !busWrite && !busOk) |=> (statVal[57:26] == 32'hFFFF_FFFF));

  p_write_done_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    (capture && busWrite) |=> (statVal == 64'h800));

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite && idx == 2'd2 && !capture) |=> (statVal == 64'd0));

  p_no_effect_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && (idx == 2'd1 || idx == 2'd2) && !capture) |=> $stable(statVal));
endmodule

bind ind_reg_bridge ind_reg_bridge_chk #(.REG_ADDR_W(REG_ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regValid (regValid),
  .regWrite (regWrite),
  .regAddr  (regAddr),
  .busReq   (busReq),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busSize  (busSize),
  .busAck   (busAck),
  .busOk    (busOk),
  .statVal  (statVal)
);

// File: tb/ind_reg_bridge_bench.sv
`timescale 1ns/1ps
module ind_reg_bridge_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;
  logic        busReq;
  logic        busWrite;
  logic [31:0] busAddr;
  logic [2:0]  busSize;
  logic [31:0] busWdata;
  logic        busAck = 1'b0;
  logic        busOk = 1'b0;
  logic [31:0] busRdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ind_reg_bridge u_ind_reg_bridge (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .busAck(busAck), .busOk(busOk), .busRdata(busRdata)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] cmdWord(input bit rd, input logic [3:0] sz, input logic [31:0] a);
    logic [63:0] w = '0;
    w[48]    = rd;
    w[59:56] = sz;
    w[31:0]  = a;
    return w;
  endfunction

  function automatic logic [2:0] expSize(input logic [3:0] sz);
    return (sz == 4'd0 || sz > 4'd4) ? 3'd4 : sz[2:0];
  endfunction

  function automatic logic [63:0] expRead(input logic [3:0] sz, input bit ok, input logic [31:0] rd);
    logic [31:0] m;
    if (!ok) return 64'h800 | ({32'd0, 32'hFFFF_FFFF} << 26);
    m = 32'hFFFF_FFFF << (8 * (4 - int'(expSize(sz))));
    return 64'h800 | ({32'd0, rd & m} << 26);
  endfunction

  // all access tasks start and end at a falling edge
  task automatic regWr(input logic [1:0] idx, input logic [63:0] d);
    regValid = 1'b1; regWrite = 1'b1; regAddr = {1'b0, idx, 3'b000}; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic regRd(input logic [1:0] idx, output logic [63:0] d);
    regValid = 1'b1; regWrite = 1'b0; regAddr = {1'b0, idx, 3'b000};
    #1 d = regRdata;
    @(negedge clk);
    regValid = 1'b0;
  endtask

  task automatic respond(input int lat, input bit ok, input logic [31:0] rd);
    for (int i = 0; i < lat; i++) @(negedge clk);
    busAck = 1'b1; busOk = ok; busRdata = rd;
    @(negedge clk);
    busAck = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] rv;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check("R5 reset busReq", {63'd0, busReq}, 64'd0);
    regRd(2'd2, rv); check("R9 reset status", rv, 64'd0);
    regRd(2'd0, rv); check("R1 command reads zero", rv, 64'd0);
    regRd(2'd1, rv); check("R1 reset reads zero", rv, 64'd0);

    // data register
    regWr(2'd3, 64'hCAFE_F00D_1234_5678);
    regRd(2'd3, rv); check("R2 data readback", rv, 64'hCAFE_F00D_0000_0000);

    // write transaction, busOk low still gives only done
    regWr(2'd0, cmdWord(1'b0, 4'd4, 32'h1000_0040));
    check("R3 busReq raised", {63'd0, busReq}, 64'd1);
    check("R3 write addr", {32'd0, busAddr}, {32'd0, 32'h1000_0040});
    check("R3 write dir", {63'd0, busWrite}, 64'd1);
    check("R8 busWdata", {32'd0, busWdata}, {32'd0, 32'hCAFE_F00D});
    regWr(2'd3, 64'h1111_1111_0000_0000);
    check("R8 wdata held from accept", {32'd0, busWdata}, {32'd0, 32'hCAFE_F00D});
    respond(1, 1'b0, 32'h0);
    check("R5 busReq dropped", {63'd0, busReq}, 64'd0);
    // R10: reset/status writes leave status and data alone
    regWr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    regWr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    regRd(2'd3, rv); check("R10 data unchanged", rv, 64'h1111_1111_0000_0000);
    regRd(2'd2, rv); check("R8 write status done only", rv, 64'h800);
    regRd(2'd2, rv); check("R9 status cleared", rv, 64'd0);

    // size clamp and partial read
    regWr(2'd0, cmdWord(1'b1, 4'd0, 32'h0000_0003));
    check("R4 size zero clamps", {61'd0, busSize}, 64'd4);
    check("R3 read dir", {63'd0, busWrite}, 64'd0);
    // busy: second command ignored
    regWr(2'd0, cmdWord(1'b0, 4'd1, 32'hDEAD_0000));
    check("R5 busy ignores cmd addr", {32'd0, busAddr}, {32'd0, 32'h0000_0003});
    respond(2, 1'b1, 32'hA1B2_C3D4);
    check("R5 ignored cmd not started", {63'd0, busReq}, 64'd0);
    regRd(2'd2, rv); check("R6 full read", rv, expRead(4'd0, 1'b1, 32'hA1B2_C3D4));

    regWr(2'd0, cmdWord(1'b1, 4'd9, 32'h0000_0010));
    check("R4 oversize clamps", {61'd0, busSize}, 64'd4);
    respond(0, 1'b0, 32'h1234_5678);
    regRd(2'd2, rv); check("R7 failed read", rv, 64'h800 | (64'hFFFF_FFFF << 26));

    regWr(2'd0, cmdWord(1'b1, 4'd2, 32'h0000_0020));
    check("R3 size two", {61'd0, busSize}, 64'd2);
    // R9 collision: status read in the capture cycle
    busAck = 1'b1; busOk = 1'b1; busRdata = 32'h5566_7788;
    regRd(2'd2, rv);
    busAck = 1'b0;
    check("R9 read before capture", rv, 64'd0);
    regRd(2'd2, rv); check("R9 capture wins over clear", rv, expRead(4'd2, 1'b1, 32'h5566_7788));

    // randomized mix
    for (int n = 0; n < 60; n++) begin
      bit          rd  = $urandom_range(0, 1) == 1;
      logic [3:0]  sz  = 4'($urandom_range(0, 15));
      logic [31:0] a   = $urandom;
      logic [31:0] dv  = $urandom;
      logic [31:0] bd  = $urandom;
      bit          ok  = $urandom_range(0, 3) != 0;
      int          lat = $urandom_range(0, 3);
      regWr(2'd3, {dv, 32'h0});
      regWr(2'd0, cmdWord(rd, sz, a));
      check("R3 random addr", {32'd0, busAddr}, {32'd0, a});
      check("R4 random size", {61'd0, busSize}, {61'd0, expSize(sz)});
      if (!rd) check("R8 random wdata", {32'd0, busWdata}, {32'd0, dv});
      respond(lat, ok, bd);
      check("R5 random drop", {63'd0, busReq}, 64'd0);
      regRd(2'd2, rv);
      if (rd) check(ok ? "R6 random read" : "R7 random fail", rv, expRead(sz, ok, bd));
      else    check("R8 random write status", rv, 64'h800);
      regRd(2'd2, rv); check("R9 random clear", rv, 64'd0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule